// File: doc/BRIEF.md
# Per-Pin Digital Glitch Filter

This block cleans up a bank of already-synchronized digital pin inputs before they reach edge detection and data-input logic. Each pin has its own filter counter. A change on a pin reaches the output only once the new level has been held for more filter ticks than a programmable width. Shorter excursions are swallowed. The width and the filter clock choice are shared by every pin of the bank. Each pin can be switched between filtered operation and a direct bypass.

The filter clock is modelled as a clock-enable on the bus clock. With the bus-rate choice every cycle is a tick. With the slow choice only cycles on which the slow-tick strobe is high count as ticks. The slow-tick strobe stands for a pulse from a low-rate (about 1 kHz) source. Software is expected to change the width or the clock choice only while every filter is disabled. A change made while filters are running gives an undefined filtering result for that episode, but the counters can never become stuck.

Top module: `pin_glitch_filter`

## Requirements
- R1: When a pin's enable bit (bit i of `filt_en_i` for pin i) is 0, `pin_out_o[i]` equals `pin_sync_i[i]` in the same cycle, with no register in the path.
- R2: With the filter enabled, a level change that is sampled on P consecutive filter ticks is absorbed when P is no more than `filt_width_i`, and the output keeps its old level.
- R3: A level change held for more than `filt_width_i` ticks reaches the output on the clock edge of the (width+1)-th tick that sees it. At bus rate this is edge W+1 after the input changed. The new output level is always the input value sampled at that edge.
- R4: With a width of 0, an enabled pin follows its input one clock later at bus rate.
- R5: With `filt_clk_sel_i` = 1, the counters advance only on cycles where `slow_tick_i` is 1. On any other cycle neither the count nor the output of an enabled pin changes.
- R6: The count is not cumulative. Whenever the input equals the current output, the pin's counter returns to zero, so repeated short glitches each shorter than the limit never pass.
- R7: While a pin is disabled its filter state tracks the input. Enabling the pin therefore produces no output edge when the input is steady.
- R8: Pins are filtered independently. Activity on one pin never changes another pin's output.
- R9: While `rst_n` is low, all filtered levels and counters are cleared, so every enabled pin outputs 0.
- R10: Lowering the width while a count is in progress cannot stall the filter. A pending change whose count already reaches the new width passes on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_sync_i | input | 32 | Synchronized pin levels |
| filt_en_i | input | 32 | Per-pin filter enable, bit i for pin i |
| filt_width_i | input | 5 | Largest glitch length in ticks that is removed |
| filt_clk_sel_i | input | 1 | Filter clock: 0 bus clock, 1 slow tick |
| slow_tick_i | input | 1 | One-cycle strobe from the slow source |
| pin_out_o | output | 32 | Filtered pin levels |

## Verification
The bypass path of a disabled pin is combinational, so it is checked in the same cycle, one time unit after the input is driven. A filtered pin's output moves on the clock edge of the (W+1)-th qualifying tick after its input changed. Enabling a pin has no delay at all. The bench drives inputs on the falling edge and advances its expected-value model on the rising edge. It then compares at the next falling edge, so every check lands one full edge after the register it depends on has loaded. The directed cases count edges explicitly and sample at edge W for "still old" and at edge W+1 for "new level".

// File: rtl/pgf_pkg.sv
package pgf_pkg;

    // Filter clock choice shared by the whole bank
    typedef enum logic {
        FCLK_BUS  = 1'b0,
        FCLK_SLOW = 1'b1
    } fclk_sel_e;

    // Tick qualifier: bus rate ticks every cycle, slow rate follows the strobe
    function automatic logic fclk_tick(input fclk_sel_e sel, input logic strobe);
        return (sel == FCLK_SLOW) ? strobe : 1'b1;
    endfunction

endpackage

// File: rtl/pgf_tick_sel.sv
module pgf_tick_sel
    import pgf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic strobe_i,
    output logic tick_o
);
    fclk_sel_e sel_e;

    always_comb begin
        sel_e  = fclk_sel_e'(sel_i);
        tick_o = fclk_tick(sel_e, strobe_i);
    end

    // At bus rate no cycle is ever skipped
    assert_bus_every_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 1'b0) |-> tick_o);

endmodule

// File: rtl/pgf_pin_cell.sv
module pgf_pin_cell #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_i,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic [CW-1:0] width_i,
    output logic          out_o
);
    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } cell_st_t;

    cell_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            // bypassed: keep the stored level aligned with the input
            st_d.lvl = pin_i;
            st_d.cnt = '0;
        end else if (pin_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt >= width_i) begin
                st_d.lvl = pin_i;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = en_i ? st_q.lvl : pin_i;

    // An enabled filter only moves its level on a tick
    assert_move_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && (st_q.lvl != $past(st_q.lvl))) |-> $past(tick_i));

    // No tick, pending difference: count holds
    assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i && (pin_i != st_q.lvl)) |=> $stable(st_q.cnt));

    // A new level is always the sampled input
    assert_takes_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |-> (st_q.lvl == $past(pin_i)));

    // Agreement clears the count
    assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (pin_i == st_q.lvl)) |=> (st_q.cnt == '0));

    // Disabled filter tracks input, so enabling causes no edge
    assert_load_on_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (st_q.lvl == $past(pin_i)));

endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter #(
    parameter int NUM_PINS   = 32,
    parameter int WIDTH_BITS = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_sync_i,
    input  logic [NUM_PINS-1:0]   filt_en_i,
    input  logic [WIDTH_BITS-1:0] filt_width_i,
    input  logic                  filt_clk_sel_i,
    input  logic                  slow_tick_i,
    output logic [NUM_PINS-1:0]   pin_out_o
);
    logic tick;

    pgf_tick_sel u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (filt_clk_sel_i),
        .strobe_i (slow_tick_i),
        .tick_o   (tick)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pgf_pin_cell #(.CW(WIDTH_BITS)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_sync_i[p]),
            .en_i    (filt_en_i[p]),
            .tick_i  (tick),
            .width_i (filt_width_i),
            .out_o   (pin_out_o[p])
        );
    end

endmodule

// File: tb/sim_pin_glitch_filter.sv
module sim_pin_glitch_filter;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin = '0;
    logic [NP-1:0] en = '1;
    logic [4:0]    w = 5'd3;
    logic          sel = 1'b0;
    logic          slow = 1'b0;
    logic [NP-1:0] pout;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [NP-1:0] m_lvl = '0;
    int            m_cnt [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_glitch_filter u0 (
        .clk(clk), .rst_n(rst_n), .pin_sync_i(pin), .filt_en_i(en),
        .filt_width_i(w), .filt_clk_sel_i(sel), .slow_tick_i(slow),
        .pin_out_o(pout)
    );

    // Expected outputs from the requirement rules
    function automatic logic [NP-1:0] exp_out();
        return (en & m_lvl) | (~en & pin);
    endfunction

    function automatic void model_edge();
        logic tk;
        tk = sel ? slow : 1'b1;
        for (int i = 0; i < NP; i++) begin
            if (!en[i]) begin
                m_lvl[i] = pin[i]; m_cnt[i] = 0;
            end else if (pin[i] == m_lvl[i]) begin
                m_cnt[i] = 0;
            end else if (tk) begin
                if (m_cnt[i] >= int'(w)) begin
                    m_lvl[i] = pin[i]; m_cnt[i] = 0;
                end else begin
                    m_cnt[i] = m_cnt[i] + 1;
                end
            end
        end
    endfunction

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, pout, exp_out());
    endtask

    task automatic steps(input int n, input string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NP; i++) m_cnt[i] = 0;
        // R9: reset state with filters enabled and inputs high
        pin = '1;
        repeat (2) @(negedge clk);
        #1 chk("R9", pout, '0);
        pin = '0;
        @(negedge clk);
        m_lvl = '0;
        rst_n = 1'b1;
        step("R9");

        // R2: 3-tick glitch with width 3 is absorbed
        pin[0] = 1'b1;
        steps(3, "R2");
        chk("R2", {31'b0, pout[0]}, 32'd0);
        pin[0] = 1'b0;
        steps(2, "R2");
        chk("R2", {31'b0, pout[0]}, 32'd0);

        // R3: 4-tick change passes at edge 4, R8: pin 0 untouched
        pin[1] = 1'b1;
        steps(3, "R3");
        chk("R3", {31'b0, pout[1]}, 32'd0);
        step("R3");
        chk("R3", {31'b0, pout[1]}, 32'd1);
        chk("R8", {31'b0, pout[0]}, 32'd0);

        // R6: short low glitches separated by high do not accumulate
        pin[1] = 1'b0; steps(2, "R6");
        pin[1] = 1'b1; steps(1, "R6");
        pin[1] = 1'b0; steps(2, "R6");
        pin[1] = 1'b1; steps(1, "R6");
        chk("R6", {31'b0, pout[1]}, 32'd1);

        // R4: width 0 gives one edge of latency
        en = '0; step("R4");
        w = 5'd0; en = '1; step("R4");
        pin[2] = 1'b1;
        #1 chk("R4", {31'b0, pout[2]}, 32'd0);
        step("R4");
        chk("R4", {31'b0, pout[2]}, 32'd1);

        // R5: slow clock counts only strobed cycles
        en = '0; step("R5");
        w = 5'd1; sel = 1'b1; slow = 1'b0; en = '1; step("R5");
        pin[6] = 1'b1;
        steps(5, "R5");
        chk("R5", {31'b0, pout[6]}, 32'd0);
        slow = 1'b1;
        step("R5");
        chk("R5", {31'b0, pout[6]}, 32'd0);
        step("R5");
        chk("R5", {31'b0, pout[6]}, 32'd1);
        slow = 1'b0;

        // R10: width lowered mid-count still releases the change
        en = '0; step("R10");
        sel = 1'b0; w = 5'd20; en = '1; step("R10");
        pin[7] = 1'b1;
        steps(5, "R10");
        chk("R10", {31'b0, pout[7]}, 32'd0);
        w = 5'd2;
        step("R10");
        chk("R10", {31'b0, pout[7]}, 32'd1);

        // R1: bypass is combinational; R7: enabling makes no edge
        en = '0;
        pin[8] = 1'b1;
        #1 chk("R1", {31'b0, pout[8]}, 32'd1);
        pin[8] = 1'b0;
        #1 chk("R1", {31'b0, pout[8]}, 32'd0);
        pin[8] = 1'b1;
        step("R1");
        en = '1;
        #1 chk("R7", {31'b0, pout[8]}, 32'd1);
        step("R7");
        chk("R7", {31'b0, pout[8]}, 32'd1);

        // Random phases: config changed only with all filters off
        for (int ph = 0; ph < 40; ph++) begin
            en = '0;
            slow = 1'b0;
            step("R1");
            w = 5'($urandom % 8);
            sel = 1'($urandom % 2);
            en = $urandom;
            step("R7");
            for (int c = 0; c < 60; c++) begin
                pin = pin ^ ($urandom & $urandom & $urandom);
                slow = (($urandom % 4) == 0);
                step("R3");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule